// File: doc/BRIEF.md
# Self-configuring host register bus front end

This block sits between a host processor bus and the register file of a two-channel serial controller. The host can use several bus styles, and none is chosen by pins or parameters. The block works out the style from what it sees on the bus during the first write after reset. That write always lands in a bus configuration slot, whatever address is presented. The choices it fixes are:

- multiplexed or separate address and data;
- 8-bit or 16-bit data;
- the active level of the wait/ready output.

The choice then stays fixed until the next reset.

After configuration the block decodes every host access into a one-cycle register write or read pulse, with a register index and a channel flag. It accepts either a data strobe qualified by a read/write level, or separate read and write strobes. The sources of the address and chip select depend on the mode. A data/control input sends an access straight to the transmit or receive data register, whatever the address says. Interrupt-acknowledge cycles are recognised and answered with a pulse in place of a register read. All bus inputs pass through synchronizers first. A stub register file, with one bank per channel, is included so that accesses can be observed end to end.

Top module: `hbus_autocfg`

## Requirements
- R1: After reset the mode flags (`cfg_done`, `mode_muxed`, `mode_narrow`, `rdy_sense`) are 0, no register or acknowledge pulse is produced, `ad_oe` is 0, and `wait_rdy` idles at 1. The register file holds 0 in every location.
- R2: The first write after reset that has chip select active configures the block and sets `cfg_done`. That write produces no register write, whatever address is presented, and no register read is produced before `cfg_done` is set.
- R3: If a low pulse on `as_n` has completed before or during the configuration write, `mode_muxed` becomes 1; otherwise it becomes 0.
- R4: `mode_narrow` becomes 1 only if the configuration data word has bit 2 = 0, bit 15 = 1 and bits 14..8 all 0; every other word gives 0.
- R5: The level of `chan_sel` during the configuration write is stored as `rdy_sense`. Afterwards `wait_rdy` equals `rdy_sense` while an access is being serviced and equals its inverse when idle.
- R6: In multiplexed mode the register index is taken from `ad_in[ADDR_W-1:0]`, and the chip select from `cs_n`, at the rising edge of `as_n`. Changes on `addr_in` or `cs_n` after that edge have no effect. In separate-address mode the index comes from `addr_in` and the chip select from `cs_n` directly.
- R7: An ordinary read or write with chip select inactive produces no register pulse and leaves the register contents unchanged.
- R8: With `dc_sel` = 1, a write goes to index TX_IDX (default 14) and a read comes from index RX_IDX (default 15), whatever the address.
- R9: A falling `ds_n` with `rw` = 0 is a write and with `rw` = 1 is a read. A falling `wr_n` is a write and a falling `rd_n` is a read. Both styles give the same result.
- R10: `chan_sel` = 1 during an access selects channel A and 0 selects channel B; the two channels keep separate contents.
- R11: Each accepted access produces exactly one `reg_we` or `reg_re` pulse, one clock wide, and read data appears on `ad_out` with `ad_oe` = 1 while the strobe is held.
- R12: A read-direction strobe with `iack_n` = 0 produces one `iack_pulse` and no `reg_re`, even with chip select inactive.
- R13: Once `cfg_done` is 1 the mode flags cannot change until reset, and later writes are ordinary register writes.
- R14: In 8-bit mode only `ad_in[7:0]` is stored on a write, and `ad_out[15:8]` reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | Direction with ds_n: 1 read, 0 write |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| chan_sel | input | 1 | Channel select (1 = A); sampled for ready sense at configuration |
| dc_sel | input | 1 | Data/control select: 1 = direct data register access |
| iack_n | input | 1 | Interrupt-acknowledge status, active low |
| addr_in | input | ADDR_W | Separate address lines |
| ad_in | input | DATA_W | Address/data bus, input side |
| ad_out | output | DATA_W | Read data, output side |
| ad_oe | output | 1 | Read data valid / drive enable |
| wait_rdy | output | 1 | Wait/ready with configured sense |
| iack_pulse | output | 1 | One-cycle interrupt-acknowledge pulse |
| reg_we | output | 1 | One-cycle register write pulse |
| reg_re | output | 1 | One-cycle register read pulse |
| reg_addr | output | ADDR_W | Register index of the access |
| reg_chan_a | output | 1 | 1 = channel A, 0 = channel B |
| reg_wdata | output | DATA_W | Register write data |
| cfg_done | output | 1 | Configuration locked |
| mode_muxed | output | 1 | Multiplexed address/data mode |
| mode_narrow | output | 1 | 8-bit data mode |
| rdy_sense | output | 1 | Active level of wait_rdy |

## Verification
Every combination of three choices is run from reset:

- an address-strobe pulse before the configuration write, or none;
- a configuration word that qualifies for 8-bit mode, or one that does not;
- channel select high or low at configuration.

Within each combination, all indices of both channels are written with arithmetic patterns and read back through alternating strobe styles. This separates channel-bank mix-ups, byte masking, address-source errors in the two address modes and direction decode. A separate sweep of configuration words isolates each field of the 8-bit rule (bit 2, bit 15, bits 14..8). Direct data accesses, writes with chip select inactive and acknowledge cycles without chip select are each run in both address modes.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef struct packed {
      logic muxed;
      logic narrow;
      logic rdy_pos;
   } bus_mode_t;

   localparam int unsigned NARROW_W    = 8;
   localparam int unsigned NARROW_SBIT = 2;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hbus_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= INIT;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hbus_cfg.sv
module hbus_cfg
   import hbus_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      as_rise,
   input  logic      cfg_wr,
   input  logic      narrow_req,
   input  logic      chan_lvl,
   output logic      as_seen,
   output logic      locked,
   output bus_mode_t mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_seen <= 1'b0;
         locked  <= 1'b0;
         mode    <= '0;
      end else begin
         if (!locked && as_rise) as_seen <= 1'b1;
         if (cfg_wr && !locked) begin
            locked       <= 1'b1;
            mode.muxed   <= as_seen | as_rise;
            mode.narrow  <= narrow_req;
            mode.rdy_pos <= chan_lvl;
         end
      end
   end

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
   import hbus_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned TX_IDX = 14,
   parameter int unsigned RX_IDX = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_n_s,
   input  logic              ds_n_s,
   input  logic              rd_n_s,
   input  logic              wr_n_s,
   input  logic              cs_n_s,
   input  logic              iack_n_s,
   input  logic              rw_s,
   input  logic              chan_s,
   input  logic              dc_s,
   input  logic [DATA_W-1:0] ad_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic              locked,
   input  logic              as_seen,
   input  logic              mode_muxed,
   input  logic              mode_narrow,
   output logic              as_rise,
   output logic              cfg_wr,
   output logic              narrow_req,
   output logic              reg_we,
   output logic              reg_re,
   output logic              iack_pulse,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_chan_a,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              serviced
);

   localparam logic [ADDR_W-1:0] TX_A = ADDR_W'(TX_IDX);
   localparam logic [ADDR_W-1:0] RX_A = ADDR_W'(RX_IDX);
   localparam int unsigned HI_W = DATA_W - NARROW_W - 1;

   logic              as_prev, strobe_prev, cs_lat;
   logic [ADDR_W-1:0] addr_lat;
   logic              muxed_now, cs_on, strobe_on, start;
   logic              is_wr, is_rd, is_iack, acc_wr, acc_rd, iack_go;
   logic [ADDR_W-1:0] addr_pick;
   logic [DATA_W-1:0] wdata_pick;

   assign as_rise   = as_n_s & ~as_prev;
   assign muxed_now = locked ? mode_muxed : as_seen;
   assign cs_on     = muxed_now ? cs_lat : ~cs_n_s;
   assign strobe_on = ~ds_n_s | ~rd_n_s | ~wr_n_s;
   assign start     = strobe_on & ~strobe_prev;
   assign is_wr     = ~wr_n_s | (~ds_n_s & ~rw_s);
   assign is_rd     = ~rd_n_s | (~ds_n_s & rw_s);
   assign is_iack   = ~iack_n_s & is_rd;

   assign cfg_wr  = start & is_wr & ~is_rd & cs_on & ~locked;
   assign acc_wr  = start & is_wr & ~is_rd & cs_on & locked;
   assign acc_rd  = start & is_rd & ~is_iack & cs_on & locked;
   assign iack_go = start & is_iack;

   assign narrow_req = ad_s[DATA_W-1] & ~(|ad_s[DATA_W-2 -: HI_W]) & ~ad_s[NARROW_SBIT];

   always_comb begin
      if (dc_s)           addr_pick = is_wr ? TX_A : RX_A;
      else if (muxed_now) addr_pick = addr_lat;
      else                addr_pick = addr_s;
   end

   always_comb begin
      wdata_pick = ad_s;
      if (mode_narrow) wdata_pick[DATA_W-1:NARROW_W] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_prev     <= 1'b1;
         strobe_prev <= 1'b0;
         cs_lat      <= 1'b0;
         addr_lat    <= '0;
         reg_we      <= 1'b0;
         reg_re      <= 1'b0;
         iack_pulse  <= 1'b0;
         reg_addr    <= '0;
         reg_chan_a  <= 1'b0;
         reg_wdata   <= '0;
         serviced    <= 1'b0;
      end else begin
         as_prev     <= as_n_s;
         strobe_prev <= strobe_on;
         if (as_rise) begin
            addr_lat <= ad_s[ADDR_W-1:0];
            cs_lat   <= ~cs_n_s;
         end
         reg_we     <= acc_wr;
         reg_re     <= acc_rd;
         iack_pulse <= iack_go;
         if (acc_wr || acc_rd) begin
            reg_addr   <= addr_pick;
            reg_chan_a <= chan_s;
            reg_wdata  <= wdata_pick;
         end
         if (!strobe_on)                                  serviced <= 1'b0;
         else if (cfg_wr || acc_wr || acc_rd || iack_go) serviced <= 1'b1;
      end
   end

endmodule

// File: rtl/hbus_regstub.sv
module hbus_regstub #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic              chan_a,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned NREG  = 2 ** ADDR_W;
   localparam int unsigned NCHAN = 2;

   logic [NCHAN-1:0][DATA_W-1:0] ch_rdata;

   for (genvar ch = 0; ch < NCHAN; ch++) begin : g_bank
      logic [DATA_W-1:0] mem [NREG];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
         end else if (we && (chan_a == (ch == 1))) begin
            mem[addr] <= wdata;
         end
      end
      assign ch_rdata[ch] = mem[addr];
   end

   assign rdata = chan_a ? ch_rdata[1] : ch_rdata[0];

endmodule

// File: rtl/hbus_autocfg.sv
module hbus_autocfg
   import hbus_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned TX_IDX      = 14,
   parameter int unsigned RX_IDX      = 15,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_n,
   input  logic              ds_n,
   input  logic              rw,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              cs_n,
   input  logic              chan_sel,
   input  logic              dc_sel,
   input  logic              iack_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              wait_rdy,
   output logic              iack_pulse,
   output logic              reg_we,
   output logic              reg_re,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_chan_a,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              cfg_done,
   output logic              mode_muxed,
   output logic              mode_narrow,
   output logic              rdy_sense
);

   localparam int unsigned NREG  = 2 ** ADDR_W;
   localparam int unsigned CTL_W = 9;

   if (DATA_W != 16) begin : g_bad_data_w
      $error("hbus_autocfg: DATA_W must be 16");
   end
   if (TX_IDX >= NREG || RX_IDX >= NREG || TX_IDX == RX_IDX) begin : g_bad_idx
      $error("hbus_autocfg: data register indices invalid");
   end

   logic [CTL_W-1:0]  ctl_raw, ctl_s;
   logic [DATA_W-1:0] ad_s;
   logic [ADDR_W-1:0] addr_s;
   logic              as_rise, cfg_wr, narrow_req, as_seen, locked, serviced;
   bus_mode_t         mode;
   logic [DATA_W-1:0] stub_rdata, rd_mask;
   logic              oe_q;
   logic [DATA_W-1:0] out_q;

   assign ctl_raw = {as_n, ds_n, rd_n, wr_n, cs_n, iack_n, rw, chan_sel, dc_sel};

   hbus_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .INIT(9'b111111_100)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));
   hbus_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_ad (
      .clk(clk), .rst_n(rst_n), .d(ad_in), .q(ad_s));
   hbus_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_addr (
      .clk(clk), .rst_n(rst_n), .d(addr_in), .q(addr_s));

   hbus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TX_IDX(TX_IDX), .RX_IDX(RX_IDX)) u_decode (
      .clk(clk), .rst_n(rst_n),
      .as_n_s(ctl_s[8]), .ds_n_s(ctl_s[7]), .rd_n_s(ctl_s[6]), .wr_n_s(ctl_s[5]),
      .cs_n_s(ctl_s[4]), .iack_n_s(ctl_s[3]), .rw_s(ctl_s[2]), .chan_s(ctl_s[1]),
      .dc_s(ctl_s[0]), .ad_s(ad_s), .addr_s(addr_s),
      .locked(locked), .as_seen(as_seen),
      .mode_muxed(mode.muxed), .mode_narrow(mode.narrow),
      .as_rise(as_rise), .cfg_wr(cfg_wr), .narrow_req(narrow_req),
      .reg_we(reg_we), .reg_re(reg_re), .iack_pulse(iack_pulse),
      .reg_addr(reg_addr), .reg_chan_a(reg_chan_a), .reg_wdata(reg_wdata),
      .serviced(serviced));

   hbus_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .as_rise(as_rise), .cfg_wr(cfg_wr),
      .narrow_req(narrow_req), .chan_lvl(ctl_s[1]),
      .as_seen(as_seen), .locked(locked), .mode(mode));

   hbus_regstub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .chan_a(reg_chan_a), .wdata(reg_wdata), .rdata(stub_rdata));

   always_comb begin
      rd_mask = '1;
      if (mode.narrow) rd_mask[DATA_W-1:NARROW_W] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         oe_q  <= 1'b0;
      end else begin
         if (reg_re) begin
            out_q <= stub_rdata & rd_mask;
            oe_q  <= 1'b1;
         end else if (!serviced) begin
            oe_q <= 1'b0;
         end
      end
   end

   assign ad_out      = out_q;
   assign ad_oe       = oe_q;
   assign wait_rdy    = mode.rdy_pos ? serviced : ~serviced;
   assign cfg_done    = locked;
   assign mode_muxed  = mode.muxed;
   assign mode_narrow = mode.narrow;
   assign rdy_sense   = mode.rdy_pos;

endmodule

// File: rtl/hbus_chk.sv
module hbus_chk (
   input logic clk,
   input logic rst_n,
   input logic reg_we,
   input logic reg_re,
   input logic iack_pulse,
   input logic cfg_done,
   input logic mode_muxed,
   input logic mode_narrow,
   input logic rdy_sense
);

   p_we_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   p_re_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

   p_dir_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));

   p_iack_no_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      iack_pulse |-> !reg_re);

   p_no_access_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> (!reg_we && !reg_re));

   p_mode_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> (cfg_done && $stable(mode_muxed) && $stable(mode_narrow) && $stable(rdy_sense)));

endmodule

bind hbus_autocfg hbus_chk u_hbus_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
   .iack_pulse(iack_pulse), .cfg_done(cfg_done), .mode_muxed(mode_muxed),
   .mode_narrow(mode_narrow), .rdy_sense(rdy_sense));

// File: tb/test_hbus_autocfg.sv
module test_hbus_autocfg;

   localparam int CLK_PER = 10;
   localparam int AW = 4;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic as_n = 1, ds_n = 1, rw = 1, rd_n = 1, wr_n = 1, cs_n = 1;
   logic chan_sel = 0, dc_sel = 0, iack_n = 1;
   logic [AW-1:0] addr_in = '0;
   logic [DW-1:0] ad_in = '0;
   logic [DW-1:0] ad_out;
   logic ad_oe, wait_rdy, iack_pulse, reg_we, reg_re, reg_chan_a;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata;
   logic cfg_done, mode_muxed, mode_narrow, rdy_sense;

   int nchk = 0, nfail = 0;
   int cnt_we = 0, cnt_re = 0, cnt_ia = 0, run_we = 0, run_re = 0, max_run = 0;
   int d_we, d_re, d_ia;
   bit muxd = 0;
   logic [DW-1:0] rd_val;
   logic oe_seen, wr_seen;

   always #(CLK_PER/2) clk = ~clk;

   hbus_autocfg i_hbus_autocfg (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .rw(rw), .rd_n(rd_n),
      .wr_n(wr_n), .cs_n(cs_n), .chan_sel(chan_sel), .dc_sel(dc_sel), .iack_n(iack_n),
      .addr_in(addr_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
      .wait_rdy(wait_rdy), .iack_pulse(iack_pulse), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_chan_a(reg_chan_a), .reg_wdata(reg_wdata),
      .cfg_done(cfg_done), .mode_muxed(mode_muxed), .mode_narrow(mode_narrow),
      .rdy_sense(rdy_sense));

   always @(negedge clk) begin
      if (reg_we) cnt_we++;
      if (reg_re) cnt_re++;
      if (iack_pulse) cnt_ia++;
      run_we = reg_we ? run_we + 1 : 0;
      run_re = reg_re ? run_re + 1 : 0;
      if (run_we > max_run) max_run = run_we;
      if (run_re > max_run) max_run = run_re;
   end

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; muxd = 0;
      as_n = 1; ds_n = 1; rw = 1; rd_n = 1; wr_n = 1; cs_n = 1;
      chan_sel = 0; dc_sel = 0; iack_n = 1; addr_in = '0; ad_in = '0;
      cyc(3);
      rst_n = 1;
      cyc(4);
   endtask

   // style 0: ds_n with rw; style 1: separate rd_n / wr_n
   task automatic access(input bit is_wr, input bit style, input logic [AW-1:0] addr,
                         input logic [DW-1:0] data, input bit chan, input bit dc,
                         input bit cs_act, input bit iack);
      int b_we, b_re, b_ia;
      chan_sel = chan; dc_sel = dc;
      if (muxd) begin
         addr_in = ~addr;
         ad_in = {{(DW-AW){1'b0}}, addr};
         cs_n = !cs_act;
         cyc(1); as_n = 0; cyc(4); as_n = 1; cyc(4);
         cs_n = 1;
      end else begin
         addr_in = addr;
         cs_n = !cs_act;
      end
      ad_in = is_wr ? data : ~data;
      iack_n = !iack;
      cyc(3);
      b_we = cnt_we; b_re = cnt_re; b_ia = cnt_ia;
      if (style == 0) begin rw = !is_wr; cyc(1); ds_n = 0; end
      else if (is_wr) wr_n = 0;
      else rd_n = 0;
      cyc(9);
      rd_val = ad_out; oe_seen = ad_oe; wr_seen = wait_rdy;
      ds_n = 1; rd_n = 1; wr_n = 1;
      cyc(6);
      cs_n = 1; iack_n = 1; dc_sel = 0; rw = 1;
      cyc(2);
      d_we = cnt_we - b_we; d_re = cnt_re - b_re; d_ia = cnt_ia - b_ia;
   endtask

   function automatic logic [DW-1:0] pat(input int cfg, input int ch, input int a);
      logic [DW-1:0] v;
      v = DW'(a * 16'h0101) ^ (ch != 0 ? 16'hA5C3 : 16'h3C5A) ^ DW'(cfg * 16'h1111);
      return v;
   endfunction

   initial begin
      #(CLK_PER * 200000);
      nchk++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      // configuration-word sweep for the 8-bit rule (R4), separate-address mode
      for (int k = 0; k < 6; k++) begin
         logic [DW-1:0] w;
         bit exp_n;
         case (k)
            0: w = 16'h8000;
            1: w = 16'h8004;
            2: w = 16'hC000;
            3: w = 16'h0000;
            4: w = 16'h8100;
            default: w = 16'h80FB;
         endcase
         exp_n = (w[15] == 1'b1) && (w[14:8] == 7'h0) && (w[2] == 1'b0);
         do_reset();
         access(1, k[0], 4'h3, w, 0, 0, 1, 0);
         chk(mode_narrow == exp_n, "R4 narrow decode", {15'h0, mode_narrow}, {15'h0, exp_n});
         chk(mode_muxed == 1'b0, "R3 no strobe gives separate mode", {15'h0, mode_muxed}, 16'h0);
      end

      for (int cfg = 0; cfg < 8; cfg++) begin
         bit with_as, narrow, sense;
         logic [DW-1:0] mask, exp;
         with_as = cfg[0]; narrow = cfg[1]; sense = cfg[2];
         mask = narrow ? 16'h00FF : 16'hFFFF;
         do_reset();
         // R1 reset state
         chk(cfg_done == 0 && mode_muxed == 0 && mode_narrow == 0 && rdy_sense == 0,
             "R1 mode flags after reset", {12'h0, cfg_done, mode_muxed, mode_narrow, rdy_sense}, 16'h0);
         chk(reg_we == 0 && reg_re == 0 && iack_pulse == 0 && ad_oe == 0,
             "R1 outputs quiet after reset", {12'h0, reg_we, reg_re, iack_pulse, ad_oe}, 16'h0);
         chk(wait_rdy == 1'b1, "R1 wait idle level", {15'h0, wait_rdy}, 16'h1);

         // configuration write to index 5
         muxd = with_as;
         access(1, cfg[1], 4'h5, narrow ? 16'h80F3 : 16'h80F7, sense, 0, 1, 0);
         chk(cfg_done == 1'b1, "R2 config locks", {15'h0, cfg_done}, 16'h1);
         chk(d_we == 0, "R2 config write not a register write", DW'(d_we), 16'h0);
         chk(mode_muxed == with_as, "R3 mux detect", {15'h0, mode_muxed}, {15'h0, with_as});
         chk(mode_narrow == narrow, "R4 narrow detect", {15'h0, mode_narrow}, {15'h0, narrow});
         chk(rdy_sense == sense, "R5 sense latched", {15'h0, rdy_sense}, {15'h0, sense});
         chk(wait_rdy == !sense, "R5 idle wait level", {15'h0, wait_rdy}, {15'h0, !sense});

         access(0, 0, 4'h5, 16'h0, 1, 0, 1, 0);
         chk(rd_val == 16'h0, "R2 addressed register untouched by config", rd_val, 16'h0);
         access(0, 0, 4'h5, 16'h0, 0, 0, 1, 0);
         chk(rd_val == 16'h0, "R2 channel B register untouched by config", rd_val, 16'h0);
         chk(wr_seen == sense, "R5 active wait level", {15'h0, wr_seen}, {15'h0, sense});
         chk(oe_seen == 1'b1, "R11 read drives bus", {15'h0, oe_seen}, 16'h1);

         // full write sweep, both channels, alternating strobe style
         for (int ch = 0; ch < 2; ch++) begin
            for (int a = 0; a < 16; a++) begin
               access(1, a[0], AW'(a), pat(cfg, ch, a), ch[0], 0, 1, 0);
               chk(d_we == 1 && d_re == 0, "R11 one write pulse (R9 style)", DW'(d_we), 16'h1);
            end
         end
         for (int ch = 0; ch < 2; ch++) begin
            for (int a = 0; a < 16; a++) begin
               access(0, !a[0], AW'(a), 16'h0, ch[0], 0, 1, 0);
               exp = pat(cfg, ch, a) & mask;
               chk(rd_val == exp, with_as ? "R10 R6 R14 R9 readback" : "R10 R14 R9 readback", rd_val, exp);
               chk(d_re == 1 && d_we == 0, "R11 one read pulse", DW'(d_re), 16'h1);
            end
         end

         // direct data register access (R8)
         access(1, 1, 4'h3, 16'h1234 ^ DW'(cfg), 1, 1, 1, 0);
         access(0, 0, 4'(14), 16'h0, 1, 0, 1, 0);
         exp = (16'h1234 ^ DW'(cfg)) & mask;
         chk(rd_val == exp, "R8 direct write to transmit index", rd_val, exp);
         access(1, 0, 4'(15), 16'h5A0F, 0, 0, 1, 0);
         access(0, 1, 4'h2, 16'h0, 0, 1, 1, 0);
         exp = 16'h5A0F & mask;
         chk(rd_val == exp, "R8 direct read from receive index", rd_val, exp);

         // chip select inactive (R7)
         access(1, 0, 4'h7, 16'hDEAD, 1, 0, 0, 0);
         chk(d_we == 0, "R7 no pulse without chip select", DW'(d_we), 16'h0);
         access(0, 1, 4'h7, 16'h0, 1, 0, 1, 0);
         exp = pat(cfg, 1, 7) & mask;
         chk(rd_val == exp, "R7 register unchanged", rd_val, exp);

         // interrupt acknowledge without chip select (R12)
         access(0, cfg[1], 4'h1, 16'h0, 0, 0, 0, 1);
         chk(d_ia == 1 && d_re == 0, "R12 acknowledge pulse instead of read",
             {DW'(d_ia)}, 16'h1);

         // later write with a mode-like pattern (R13)
         access(1, 0, 4'h9, 16'h8000, !sense, 0, 1, 0);
         chk(d_we == 1, "R13 later write is a register write", DW'(d_we), 16'h1);
         chk(mode_muxed == with_as && mode_narrow == narrow && rdy_sense == sense,
             "R13 mode unchanged", {13'h0, mode_muxed, mode_narrow, rdy_sense},
             {13'h0, with_as, narrow, sense});
         chk(max_run <= 1, "R11 pulse width", DW'(max_run), 16'h1);
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule